// File: doc/BRIEF.md
# Framed Link Packet Transmitter

This block turns one link-layer packet into a delimited, byte-stuffed byte stream for a three-wire serial host transport. A caller presents a packet type, a payload length of up to 4095 bytes and the acknowledge number to advertise, and pulses start. The block then builds a four-byte header and sends the opening delimiter, the header, the payload pulled from a ready/valid stream, and the closing delimiter. Any byte that collides with the delimiter or the escape code is replaced by a two-byte escape sequence as it goes out.

The block owns the 3-bit outgoing sequence counter. Packets of a reliable type take the current value and advance it modulo 8. All other packets carry zero in that field and leave the counter alone. The output is a byte stream with valid/ready handshaking, meant to feed a serializer. The block stalls cleanly at any byte, including between the two halves of an escape.

Top module: `slip_frame_tx`

## Requirements
- R1: Each frame begins and ends with the delimiter byte 0xC0, and no 0xC0 appears between those two bytes.
- R2: Inside a frame, a byte 0xC0 is sent as 0xDB followed by 0xDC. A byte 0xDB is sent as 0xDB followed by 0xDD. Every other byte is sent unchanged.
- R3: Header byte 0 (first after the opening delimiter) holds the sequence field in bits [2:0], the acknowledge number in bits [5:3], 0 in bit 6 and the reliable flag in bit 7.
- R4: Header byte 1 holds the packet type in bits [3:0] and length bits [3:0] in bits [7:4]. Header byte 2 holds length bits [11:4].
- R5: Header byte 3 equals the bitwise inverse of (byte0 + byte1 + byte2) mod 256.
- R6: Types 1, 2, 4 and 5 are reliable. They set the reliable flag and carry the current counter value, and the counter (seq_o) then advances by one modulo 8.
- R7: All other types send 0 in the sequence field, clear the reliable flag and leave seq_o unchanged.
- R8: Header bytes are escaped by the same rule as payload bytes.
- R9: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o stays unchanged on the next cycle. This includes the second byte of an escape.
- R10: A start pulse while busy_o is high is ignored. The frame in progress and seq_o are unaffected.
- R11: done_o is high for exactly one cycle, the cycle after the closing delimiter is accepted.
- R12: Payload bytes are taken in order, exactly pkt_len_i of them. A zero-length packet goes from the header straight to the closing delimiter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a frame (honoured only when idle) |
| pkt_type_i | input | 4 | Packet type, sampled at start |
| pkt_len_i | input | 12 | Payload length in bytes, sampled at start |
| ack_num_i | input | 3 | Acknowledge number to send, sampled at start |
| pl_valid_i | input | 1 | Payload byte valid |
| pl_data_i | input | 8 | Payload byte |
| pl_ready_o | output | 1 | Payload byte taken this cycle |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_ready_i | input | 1 | Downstream accepts output byte |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the closing delimiter |
| seq_o | output | 3 | Current outgoing sequence counter |

## Verification
A bad sequence counter shows up on seq_o in the cycle after the start pulse. It shows up again in bits [2:0] of the first header byte, a few output bytes later. A wrong escape pending flag or a wrong header index corrupts the decoded header or the payload of the same frame, and the checksum byte exposes that within the header. A wrong remaining-byte count changes the number of payload bytes taken and moves the closing delimiter and done_o, so the frame length and done timing show it by the end of that frame.

// File: rtl/slip_tx_pkg.sv
package slip_tx_pkg;
    localparam int TYPE_W = 4;
    localparam int LEN_W  = 12;
    localparam int SEQ_W  = 3;
    localparam int HDR_N  = 4;
    localparam int HIDX_W = $clog2(HDR_N);

    localparam logic [7:0] FRAME_MARK = 8'hC0;
    localparam logic [7:0] ESC_LEAD   = 8'hDB;
    localparam logic [7:0] ESC_MARK   = 8'hDC;
    localparam logic [7:0] ESC_SELF   = 8'hDD;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_HDR,
        ST_PAY,
        ST_CLOSE
    } tx_state_e;

    function automatic logic type_reliable(input logic [TYPE_W-1:0] t);
        return (t == 4'd1) || (t == 4'd2) || (t == 4'd4) || (t == 4'd5);
    endfunction
endpackage

// File: rtl/slip_hdr_pack.sv
module slip_hdr_pack
    import slip_tx_pkg::*;
(
    input  logic [TYPE_W-1:0]     pkt_type_i,
    input  logic [LEN_W-1:0]      pkt_len_i,
    input  logic [SEQ_W-1:0]      ack_i,
    input  logic [SEQ_W-1:0]      seq_i,
    output logic [HDR_N-1:0][7:0] hdr_o,
    output logic                  reliable_o
);
    logic [7:0] sum8;

    always_comb begin
        reliable_o = type_reliable(pkt_type_i);
        hdr_o[0]   = {reliable_o, 1'b0, ack_i, (reliable_o ? seq_i : 3'd0)};
        hdr_o[1]   = {pkt_len_i[3:0], pkt_type_i};
        hdr_o[2]   = pkt_len_i[11:4];
        sum8       = hdr_o[0] + hdr_o[1] + hdr_o[2];
        hdr_o[3]   = ~sum8;
    end
endmodule

// File: rtl/slip_esc_map.sv
module slip_esc_map
    import slip_tx_pkg::*;
(
    input  logic [7:0] raw_i,
    output logic [7:0] first_o,
    output logic [7:0] second_o,
    output logic       split_o
);
    always_comb begin
        split_o  = (raw_i == FRAME_MARK) || (raw_i == ESC_LEAD);
        first_o  = split_o ? ESC_LEAD : raw_i;
        second_o = (raw_i == FRAME_MARK) ? ESC_MARK : ESC_SELF;
    end
endmodule

// File: rtl/slip_frame_tx.sv
module slip_frame_tx
    import slip_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TYPE_W-1:0] pkt_type_i,
    input  logic [LEN_W-1:0]  pkt_len_i,
    input  logic [SEQ_W-1:0]  ack_num_i,
    input  logic              pl_valid_i,
    input  logic [7:0]        pl_data_i,
    output logic              pl_ready_o,
    output logic              out_valid_o,
    output logic [7:0]        out_data_o,
    input  logic              out_ready_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [SEQ_W-1:0]  seq_o
);
    typedef struct packed {
        tx_state_e                st;
        logic [HIDX_W-1:0]        hidx;
        logic [LEN_W-1:0]         rem;
        logic                     esc_pend;
        logic [7:0]               esc_tail;
        logic [HDR_N-1:0][7:0]    hdr;
        logic [SEQ_W-1:0]         seq;
        logic                     done;
    } regs_t;

    regs_t q, d;

    logic [HDR_N-1:0][7:0] hdr_new;
    logic                  rel_new;
    logic [7:0]            raw_byte, esc_first, esc_second;
    logic                  esc_split, accept;

    slip_hdr_pack u_hdr (
        .pkt_type_i (pkt_type_i),
        .pkt_len_i  (pkt_len_i),
        .ack_i      (ack_num_i),
        .seq_i      (q.seq),
        .hdr_o      (hdr_new),
        .reliable_o (rel_new)
    );

    slip_esc_map u_esc (
        .raw_i    (raw_byte),
        .first_o  (esc_first),
        .second_o (esc_second),
        .split_o  (esc_split)
    );

    always_comb begin
        raw_byte = (q.st == ST_HDR) ? q.hdr[q.hidx] : pl_data_i;

        if (q.esc_pend) begin
            out_valid_o = 1'b1;
            out_data_o  = q.esc_tail;
        end else begin
            unique case (q.st)
                ST_OPEN, ST_CLOSE: begin
                    out_valid_o = 1'b1;
                    out_data_o  = FRAME_MARK;
                end
                ST_HDR: begin
                    out_valid_o = 1'b1;
                    out_data_o  = esc_first;
                end
                ST_PAY: begin
                    out_valid_o = pl_valid_i;
                    out_data_o  = esc_first;
                end
                default: begin
                    out_valid_o = 1'b0;
                    out_data_o  = 8'h00;
                end
            endcase
        end

        accept     = out_valid_o && out_ready_i;
        pl_ready_o = (q.st == ST_PAY) && !q.esc_pend && out_ready_i;

        d      = q;
        d.done = 1'b0;
        if (q.st == ST_IDLE) begin
            if (start_i) begin
                d.st   = ST_OPEN;
                d.hdr  = hdr_new;
                d.rem  = pkt_len_i;
                d.hidx = '0;
                if (rel_new) d.seq = q.seq + 1'b1;
            end
        end else if (accept) begin
            if (q.esc_pend) begin
                d.esc_pend = 1'b0;
            end else begin
                unique case (q.st)
                    ST_OPEN: d.st = ST_HDR;
                    ST_HDR: begin
                        d.esc_pend = esc_split;
                        d.esc_tail = esc_second;
                        d.hidx     = q.hidx + 1'b1;
                        if (q.hidx == HIDX_W'(HDR_N - 1))
                            d.st = (q.rem == '0) ? ST_CLOSE : ST_PAY;
                    end
                    ST_PAY: begin
                        d.esc_pend = esc_split;
                        d.esc_tail = esc_second;
                        d.rem      = q.rem - 1'b1;
                        if (q.rem == LEN_W'(1)) d.st = ST_CLOSE;
                    end
                    ST_CLOSE: begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                    default: d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, hidx: '0, rem: '0, esc_pend: 1'b0,
                   esc_tail: 8'h00, hdr: '0, seq: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.st != ST_IDLE);
    assign done_o = q.done;
    assign seq_o  = q.seq;

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i && (q.st != ST_PAY || q.esc_pend))
        |=> (out_valid_o && $stable(out_data_o)));

    assert_esc_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.esc_pend |-> (out_data_o == ESC_MARK || out_data_o == ESC_SELF));

    assert_no_inner_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PAY && !q.esc_pend && pl_valid_i)
        |-> (out_valid_o && out_data_o != FRAME_MARK));

    assert_seq_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.seq != $past(q.seq)) |-> (q.seq == $past(q.seq) + 3'd1));

    assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(seq_o));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: tb/slip_frame_tx_tb.sv
module slip_frame_tx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  pkt_type_i = '0;
    logic [11:0] pkt_len_i = '0;
    logic [2:0]  ack_num_i = '0;
    logic        pl_valid_i = 1'b0;
    logic [7:0]  pl_data_i = '0;
    logic        pl_ready_o, out_valid_o, out_ready_i, busy_o, done_o;
    logic [7:0]  out_data_o;
    logic [2:0]  seq_o;

    int checks = 0;
    int errors = 0;
    logic [2:0] exp_seq = '0;
    logic [7:0] pay [0:4095];
    logic [7:0] exp_q [$];
    logic [7:0] got_q [$];

    always #2 clk = ~clk;

    slip_frame_tx u_dut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_rel(input logic [3:0] t);
        return t == 1 || t == 2 || t == 4 || t == 5;
    endfunction

    function automatic void push_esc(input logic [7:0] b);
        if (b == 8'hC0) begin exp_q.push_back(8'hDB); exp_q.push_back(8'hDC); end
        else if (b == 8'hDB) begin exp_q.push_back(8'hDB); exp_q.push_back(8'hDD); end
        else exp_q.push_back(b);
    endfunction

    task automatic send_frame(input logic [3:0] t, input int len, input logic [2:0] ack,
                              input int ready_pct, input bit poke_busy);
        logic [7:0] h [4];
        logic [7:0] dh [4];
        int idx, cyc, last_acc, done_cyc, hold_bad, nd, i;
        bit stall, pl_hold, seen;
        logic [7:0] stall_data;
        logic [2:0] seq_before;
        h[0] = {is_rel(t), 1'b0, ack, (is_rel(t) ? exp_seq : 3'd0)};
        h[1] = {len[3:0], t};
        h[2] = len[11:4];
        h[3] = ~(h[0] + h[1] + h[2]);
        exp_q.delete(); got_q.delete();
        exp_q.push_back(8'hC0);
        for (int k = 0; k < 4; k++) push_esc(h[k]);
        for (int k = 0; k < len; k++) push_esc(pay[k]);
        exp_q.push_back(8'hC0);

        @(negedge clk);
        start_i = 1; pkt_type_i = t; pkt_len_i = 12'(len); ack_num_i = ack;
        seq_before = seq_o;
        @(negedge clk);
        start_i = 0;
        #1;
        if (is_rel(t)) exp_seq = exp_seq + 3'd1;
        check(seq_o == exp_seq, is_rel(t) ? "R6" : "R7", "seq_o after start", seq_o, exp_seq);
        check(busy_o == 1'b1, "R10", "busy after start", busy_o, 1);
        idx = 0; cyc = 0; last_acc = -10; done_cyc = -1; hold_bad = 0;
        stall = 0; pl_hold = 0; seen = 0; stall_data = 0;
        seq_before = seq_o;
        while (cyc < 30000) begin
            if (poke_busy && cyc == 3) begin start_i = 1; pkt_type_i = 4'd2; end
            else start_i = 0;
            out_ready_i = ($urandom_range(99) < ready_pct);
            if (!pl_hold) pl_valid_i = (idx < len) && ($urandom_range(3) != 0);
            pl_data_i = (idx < len) ? pay[idx] : 8'h00;
            #1;
            if (done_o) begin done_cyc = cyc; seen = 1; break; end
            if (stall && !(out_valid_o && out_data_o == stall_data)) hold_bad++;
            stall = out_valid_o && !out_ready_i;
            stall_data = out_data_o;
            if (out_valid_o && out_ready_i) begin got_q.push_back(out_data_o); last_acc = cyc; end
            pl_hold = pl_valid_i && !pl_ready_o;
            if (pl_valid_i && pl_ready_o) idx++;
            @(negedge clk);
            cyc++;
        end
        start_i = 0; pl_valid_i = 0;
        check(seen, "R11", "done seen", seen, 1);
        check(done_cyc == last_acc + 1, "R11", "done cycle after close", done_cyc, last_acc + 1);
        check(hold_bad == 0, "R9", "stall hold violations", hold_bad, 0);
        check(idx == len, "R12", "payload bytes taken", idx, len);
        check(got_q.size() == exp_q.size(), "R1", "frame size", got_q.size(), exp_q.size());
        nd = 0;
        for (i = 0; i < got_q.size() && i < exp_q.size(); i++)
            if (got_q[i] != exp_q[i]) begin
                if (nd == 0)
                    check(0, (i <= 8) ? "R8" : "R2", $sformatf("byte %0d", i), got_q[i], exp_q[i]);
                nd++;
            end
        if (nd == 0) check(1, "R2", "stream", 0, 0);
        check(got_q.size() > 0 && got_q[0] == 8'hC0 && got_q[got_q.size()-1] == 8'hC0,
              "R1", "delimiters", got_q.size() > 0 ? got_q[0] : 0, 8'hC0);
        // decode header from the received stream
        i = 1;
        for (int k = 0; k < 4; k++) begin
            dh[k] = 8'h00;
            if (i < got_q.size()) begin
                if (got_q[i] == 8'hDB && i + 1 < got_q.size()) begin
                    dh[k] = (got_q[i+1] == 8'hDC) ? 8'hC0 : 8'hDB; i += 2;
                end else begin dh[k] = got_q[i]; i++; end
            end
        end
        check(dh[0] == h[0], "R3", "header byte0", dh[0], h[0]);
        check({dh[2], dh[1]} == {h[2], h[1]}, "R4", "header bytes1-2", {dh[2], dh[1]}, {h[2], h[1]});
        check(dh[3] == ~(dh[0] + dh[1] + dh[2]), "R5", "checksum", dh[3], ~(dh[0] + dh[1] + dh[2]));
        @(negedge clk); #1;
        check(done_o == 0 && busy_o == 0, "R11", "done single cycle", done_o, 0);
        if (poke_busy) check(seq_o == exp_seq, "R10", "seq after busy start", seq_o, exp_seq);
        seq_before = seq_o;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        out_ready_i = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(busy_o == 0 && out_valid_o == 0 && done_o == 0 && seq_o == 0,
              "R11", "reset state", {busy_o, out_valid_o, done_o, seq_o}, 0);
        rst_n = 1;
        // directed: zero-length pure acknowledge (R7, R12)
        send_frame(4'd0, 0, 3'd5, 100, 0);
        // directed: header byte1 equals 0xC0 and escape data (R8)
        for (int k = 0; k < 12; k++) pay[k] = (k % 2) ? 8'hC0 : 8'hDB;
        send_frame(4'd0, 12, 3'd3, 40, 0);
        // directed: link-control type 15 and reliable type 1 with start poked while busy (R10)
        pay[0] = 8'h01; pay[1] = 8'h7E;
        send_frame(4'd15, 2, 3'd0, 70, 0);
        pay[0] = 8'hC0; pay[1] = 8'hDB; pay[2] = 8'hC0;
        send_frame(4'd1, 3, 3'd7, 30, 1);
        // random frames, including sequence wrap
        for (int n = 0; n < 24; n++) begin
            int len;
            logic [3:0] t;
            len = $urandom_range(40);
            t = (n % 3 == 0) ? 4'($urandom_range(15)) : 4'(2 + (n % 4));
            for (int k = 0; k < len; k++)
                pay[k] = ($urandom_range(3) == 0) ? (($urandom_range(1) == 0) ? 8'hC0 : 8'hDB)
                                                  : 8'($urandom_range(255));
            send_frame(t, len, 3'($urandom_range(7)), 30 + $urandom_range(70), n == 5);
        end
        // maximum length frame
        for (int k = 0; k < 4095; k++) pay[k] = 8'((k * 37) ^ (k >> 3));
        send_frame(4'd2, 4095, 3'd1, 90, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule